// File: doc/BRIEF.md
# HDLC Frame Check Sequence Verifier

This block decides whether a received HDLC frame arrived intact. It sits after the flag detector and the zero-bit remover. It consumes the de-stuffed in-frame bytes, each taken least significant bit first, together with strobes that mark frame start, frame end and abort. A single shift engine runs a reflected CCITT CRC. A mode input selects the 16-bit or the 32-bit polynomial.

The seed value and the good-frame residue are supplied as configuration words. At frame start the seed is loaded into the CRC register. Every byte is then folded in, and that includes the received FCS bytes. At frame end the register is compared against the residue word, with no separate recomputation of the FCS. For a correct frame the residue is 0x0000_F0B8 in 16-bit mode and 0xDEBB_20E3 in 32-bit mode, and the usual seeds are 0x0000_FFFF and 0xFFFF_FFFF. The block reports one result pulse per completed frame. It reports nothing for aborted or restarted frames.

Top module: `hdlc_fcs_chk`

## Requirements
- R1: While rst_ni is low and after its release, done_o and crc_err_o are 0 and no frame is open.
- R2: A start strobe loads the seed into the CRC register and opens a frame. A byte strobed in the same cycle is folded in after the seed.
- R3: With mode32_i=0 the register folds bytes bit 0 first through the reflected polynomial 0x8408 (x^16+x^12+x^5+1). A frame carrying its complemented FCS, low byte first, ends with crc_err_o=0.
- R4: With mode32_i=1 the register uses the reflected polynomial 0xEDB88320, and a frame carrying its complemented 4-byte FCS, low byte first, ends with crc_err_o=0.
- R5: An end strobe inside an open frame closes it and raises done_o for exactly one cycle, in the cycle after the strobe. crc_err_o is high in that cycle only if the register differs from the residue word.
- R6: A frame with any corrupted bit, or an empty frame, ends with crc_err_o=1.
- R7: An abort closes the frame and produces no result. Abort takes priority over start, end and byte strobes in the same cycle.
- R8: A start strobe inside an open frame discards the bytes so far and restarts. No result is produced for the abandoned frame, and a start in the same cycle as an end wins over the end.
- R9: A byte or end strobe outside an open frame has no effect. A byte strobed in the same cycle as an end is not folded in.
- R10: With mode32_i=0 only bits 15:0 of the seed and residue words are used.
- R11: The seed is taken from preset_i at each start. A frame whose FCS was built from a different seed fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode32_i | input | 1 | 1 selects the 32-bit CRC, 0 selects the 16-bit CRC |
| preset_i | input | 32 | CRC seed loaded at frame start |
| resid_i | input | 32 | Residue expected in the register for a good frame |
| sof_i | input | 1 | Frame start strobe |
| eof_i | input | 1 | Frame end strobe |
| abort_i | input | 1 | Frame abort strobe |
| byte_vld_i | input | 1 | byte_i holds a valid in-frame byte |
| byte_i | input | 8 | De-stuffed byte, bit 0 received first |
| done_o | output | 1 | One-cycle pulse: a frame result is present |
| crc_err_o | output | 1 | FCS check failed; valid with done_o |

## Verification
The assertions take for granted that mode32_i, preset_i and resid_i are held constant while a frame is open. They assume nothing else about the strobes, because any mix of start, end, abort and byte in one cycle has a defined priority. The stimulus changes the mode and the configuration words only between frames. It deliberately drives the overlapping strobe combinations, so that the priority rules are exercised rather than avoided.

// File: rtl/hdlc_crc_pkg.sv
package hdlc_crc_pkg;
  localparam int unsigned CRC_W   = 32;
  localparam int unsigned SHORT_W = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam logic [CRC_W-1:0]   POLY_LONG  = 32'hEDB8_8320;
  localparam logic [SHORT_W-1:0] POLY_SHORT = 16'h8408;

  typedef struct packed {
    logic load;
    logic fold;
    logic check;
  } crc_ctl_t;
endpackage

// File: rtl/hdlc_crc_ctrl.sv
module hdlc_crc_ctrl
  import hdlc_crc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sof_i,
  input  logic     eof_i,
  input  logic     abort_i,
  input  logic     byte_vld_i,
  output logic     in_frame_o,
  output crc_ctl_t ctl_o
);
  logic in_frame_q, in_frame_d;

  // priority: abort > start > end > byte
  always_comb begin
    ctl_o.load  = sof_i & ~abort_i;
    ctl_o.check = eof_i & in_frame_q & ~sof_i & ~abort_i;
    ctl_o.fold  = byte_vld_i & ~abort_i & (sof_i | (in_frame_q & ~eof_i));
    if (abort_i)    in_frame_d = 1'b0;
    else if (sof_i) in_frame_d = 1'b1;
    else if (eof_i) in_frame_d = 1'b0;
    else            in_frame_d = in_frame_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_frame_q <= 1'b0;
    else         in_frame_q <= in_frame_d;
  end

  assign in_frame_o = in_frame_q;
endmodule

// File: rtl/hdlc_crc_fold.sv
module hdlc_crc_fold #(
  parameter int unsigned CRC_W   = 32,
  parameter int unsigned SHORT_W = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter logic [CRC_W-1:0]   POLY_LONG  = 32'hEDB8_8320,
  parameter logic [SHORT_W-1:0] POLY_SHORT = 16'h8408
) (
  input  logic              wide_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  localparam int unsigned PAD_W = CRC_W - SHORT_W;

  logic [CRC_W-1:0] poly;
  logic [CRC_W-1:0] stage [BYTE_W+1];

  // short mode keeps the upper bits at zero, so the right shift never leaks into bit SHORT_W-1
  assign poly     = wide_i ? POLY_LONG : {{PAD_W{1'b0}}, POLY_SHORT};
  assign stage[0] = crc_i;

  for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
    logic fb;
    assign fb           = stage[k][0] ^ data_i[k];
    assign stage[k+1]   = (stage[k] >> 1) ^ (fb ? poly : '0);
  end

  assign crc_o = stage[BYTE_W];
endmodule

// File: rtl/hdlc_crc_cmp.sv
module hdlc_crc_cmp #(
  parameter int unsigned CRC_W   = 32,
  parameter int unsigned SHORT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             check_i,
  input  logic             wide_i,
  input  logic [CRC_W-1:0] crc_i,
  input  logic [CRC_W-1:0] resid_i,
  output logic             done_o,
  output logic             err_o
);
  localparam int unsigned PAD_W = CRC_W - SHORT_W;

  logic [CRC_W-1:0] target;
  assign target = wide_i ? resid_i : {{PAD_W{1'b0}}, resid_i[SHORT_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      done_o <= check_i;
      err_o  <= check_i & (crc_i != target);
    end
  end
endmodule

// File: rtl/hdlc_fcs_chk.sv
module hdlc_fcs_chk
  import hdlc_crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode32_i,
  input  logic [CRC_W-1:0]  preset_i,
  input  logic [CRC_W-1:0]  resid_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              abort_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              done_o,
  output logic              crc_err_o
);
  localparam int unsigned PAD_W = CRC_W - SHORT_W;

  crc_ctl_t         ctl;
  logic             in_frame;
  logic [CRC_W-1:0] crc_q, seed_m, fold_in, fold_out;

  hdlc_crc_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .eof_i      (eof_i),
    .abort_i    (abort_i),
    .byte_vld_i (byte_vld_i),
    .in_frame_o (in_frame),
    .ctl_o      (ctl)
  );

  assign seed_m  = mode32_i ? preset_i : {{PAD_W{1'b0}}, preset_i[SHORT_W-1:0]};
  assign fold_in = ctl.load ? seed_m : crc_q;

  hdlc_crc_fold #(
    .CRC_W      (CRC_W),
    .SHORT_W    (SHORT_W),
    .BYTE_W     (BYTE_W),
    .POLY_LONG  (POLY_LONG),
    .POLY_SHORT (POLY_SHORT)
  ) u_fold (
    .wide_i (mode32_i),
    .crc_i  (fold_in),
    .data_i (byte_i),
    .crc_o  (fold_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       crc_q <= '0;
    else if (ctl.fold) crc_q <= fold_out;
    else if (ctl.load) crc_q <= seed_m;
  end

  hdlc_crc_cmp #(
    .CRC_W   (CRC_W),
    .SHORT_W (SHORT_W)
  ) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .check_i (ctl.check),
    .wide_i  (mode32_i),
    .crc_i   (crc_q),
    .resid_i (resid_i),
    .done_o  (done_o),
    .err_o   (crc_err_o)
  );
endmodule

// File: rtl/hdlc_fcs_chk_sva.sv
module hdlc_fcs_chk_sva
  import hdlc_crc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode32_i,
  input logic [CRC_W-1:0] preset_i,
  input logic [CRC_W-1:0] resid_i,
  input logic             sof_i,
  input logic             eof_i,
  input logic             abort_i,
  input logic             byte_vld_i,
  input logic             done_o,
  input logic             crc_err_o,
  input logic             in_frame,
  input logic [CRC_W-1:0] crc_q
);
  localparam int unsigned PAD_W = CRC_W - SHORT_W;

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (!done_o && !crc_err_o && !in_frame));

  p_seed_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_i && !abort_i && !byte_vld_i) |=>
      crc_q == ($past(mode32_i) ? $past(preset_i) : {{PAD_W{1'b0}}, $past(preset_i[SHORT_W-1:0])}));

  p_short_upper_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame && !mode32_i) |-> crc_q[CRC_W-1:SHORT_W] == '0);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_err_with_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o |-> done_o);

  p_done_needs_eof_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_i && in_frame && !sof_i && !abort_i) |=> done_o);

  p_abort_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!done_o && !in_frame));

  p_restart_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> !done_o);

  p_idle_eof_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_i && !in_frame) |=> !done_o);

  p_cfg_stable_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame && $past(in_frame) && !sof_i) |->
      ($stable(mode32_i) && $stable(preset_i) && $stable(resid_i)));
endmodule

bind hdlc_fcs_chk hdlc_fcs_chk_sva u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode32_i   (mode32_i),
  .preset_i   (preset_i),
  .resid_i    (resid_i),
  .sof_i      (sof_i),
  .eof_i      (eof_i),
  .abort_i    (abort_i),
  .byte_vld_i (byte_vld_i),
  .done_o     (done_o),
  .crc_err_o  (crc_err_o),
  .in_frame   (in_frame),
  .crc_q      (crc_q)
);

// File: tb/hdlc_fcs_chk_tb_top.sv
module hdlc_fcs_chk_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode32_i = 1'b0;
  logic [31:0] preset_i = 32'h0000_FFFF;
  logic [31:0] resid_i  = 32'h0000_F0B8;
  logic        sof_i = 1'b0, eof_i = 1'b0, abort_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic        done_o, crc_err_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  bit          m_open = 0;
  logic [31:0] m_reg  = '0;
  bit          x_done = 0, x_err = 0;

  always #5 clk_i = ~clk_i;

  hdlc_fcs_chk dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode32_i   (mode32_i),
    .preset_i   (preset_i),
    .resid_i    (resid_i),
    .sof_i      (sof_i),
    .eof_i      (eof_i),
    .abort_i    (abort_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .done_o     (done_o),
    .crc_err_o  (crc_err_o)
  );

  function automatic logic [31:0] crc_step(bit wide, logic [31:0] c, logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      bit fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
    end
    return wide ? c : {16'h0, c[15:0]};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive, update model at the edge, compare outputs at the falling edge
  task automatic cyc(string tag, bit s, bit e, bit a, bit v, logic [7:0] b);
    sof_i = s; eof_i = e; abort_i = a; byte_vld_i = v; byte_i = b;
    @(posedge clk_i);
    x_done = 0; x_err = 0;
    if (a) m_open = 0;
    else if (s) begin
      m_reg  = mode32_i ? preset_i : {16'h0, preset_i[15:0]};
      m_open = 1;
      if (v) m_reg = crc_step(mode32_i, m_reg, b);
    end else if (e) begin
      if (m_open) begin
        x_done = 1;
        x_err  = (m_reg != (mode32_i ? resid_i : {16'h0, resid_i[15:0]}));
      end
      m_open = 0;
    end else if (v && m_open) m_reg = crc_step(mode32_i, m_reg, b);
    @(negedge clk_i);
    check(tag, "done_o", {31'h0, done_o}, {31'h0, x_done});
    check(tag, "crc_err_o", {31'h0, crc_err_o}, {31'h0, x_err});
    sof_i = 0; eof_i = 0; abort_i = 0; byte_vld_i = 0;
  endtask

  // payload plus complemented FCS (low byte first), FCS built with seed
  task automatic build(bit wide, logic [31:0] seed, logic [7:0] pl[$], output logic [7:0] fr[$]);
    logic [31:0] c = wide ? seed : {16'h0, seed[15:0]};
    fr = pl;
    foreach (pl[i]) c = crc_step(wide, c, pl[i]);
    c = ~c;
    for (int i = 0; i < (wide ? 4 : 2); i++) fr.push_back(c[8*i +: 8]);
  endtask

  task automatic send(string tag, logic [7:0] fr[$], bit exp_err);
    cyc(tag, 1, 0, 0, 0, 8'h00);
    foreach (fr[i]) cyc(tag, 0, 0, 0, 1, fr[i]);
    cyc(tag, 0, 1, 0, 0, 8'h00);
    check(tag, "result pulse", {31'h0, done_o}, 32'h1);
    check(tag, "frame verdict", {31'h0, crc_err_o}, {31'h0, exp_err});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    logic [7:0] pl[$];
    logic [7:0] fr[$];
    repeat (3) @(negedge clk_i);
    check("R1", "done_o in reset", {31'h0, done_o}, 32'h0);
    check("R1", "crc_err_o in reset", {31'h0, crc_err_o}, 32'h0);
    rst_ni = 1;
    cyc("R1", 0, 0, 0, 0, 8'h00);

    // R3: 16-bit good frames, two payloads
    pl = '{8'h03, 8'h3F, 8'hA5, 8'h00, 8'hFF};
    build(0, 32'hFFFF, pl, fr); send("R3", fr, 0);
    pl = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99};
    build(0, 32'hFFFF, pl, fr); send("R3", fr, 0);
    // R6: corrupted 16-bit frame, empty frame
    fr[2] = fr[2] ^ 8'h10; send("R6", fr, 1);
    fr = {}; send("R6", fr, 1);

    // R4: 32-bit mode
    mode32_i = 1; preset_i = 32'hFFFF_FFFF; resid_i = 32'hDEBB_20E3;
    pl = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    build(1, 32'hFFFF_FFFF, pl, fr); send("R4", fr, 0);
    fr[fr.size()-1] = fr[fr.size()-1] ^ 8'h80; send("R6", fr, 1);

    // R2: byte in the start cycle is folded after the seed
    build(1, 32'hFFFF_FFFF, pl, fr);
    cyc("R2", 1, 0, 0, 1, fr[0]);
    for (int i = 1; i < fr.size(); i++) cyc("R2", 0, 0, 0, 1, fr[i]);
    cyc("R2", 0, 1, 0, 0, 8'h00);
    check("R2", "sof+byte verdict", {31'h0, crc_err_o}, 32'h0);

    // R7: abort mid-frame, then end strobe gives nothing; abort beats start
    cyc("R7", 1, 0, 0, 0, 8'h00);
    cyc("R7", 0, 0, 0, 1, 8'h5A);
    cyc("R7", 0, 0, 1, 1, 8'h5A);
    cyc("R7", 0, 1, 0, 0, 8'h00);
    check("R7", "no result after abort", {31'h0, done_o}, 32'h0);
    cyc("R7", 1, 0, 1, 0, 8'h00);
    cyc("R7", 0, 1, 0, 0, 8'h00);
    check("R7", "abort beats start", {31'h0, done_o}, 32'h0);

    // R8: restart discards earlier bytes; start beats end
    cyc("R8", 1, 0, 0, 0, 8'h00);
    cyc("R8", 0, 0, 0, 1, 8'hDE);
    cyc("R8", 0, 0, 0, 1, 8'hAD);
    cyc("R8", 1, 1, 0, 0, 8'h00);
    check("R8", "no result for abandoned frame", {31'h0, done_o}, 32'h0);
    foreach (fr[i]) cyc("R8", 0, 0, 0, 1, fr[i]);
    cyc("R8", 0, 1, 0, 0, 8'h00);
    check("R8", "restarted frame passes", {31'h0, crc_err_o}, 32'h0);

    // R9: stray bytes and end outside a frame; byte with end not folded
    cyc("R9", 0, 0, 0, 1, 8'h77);
    cyc("R9", 0, 1, 0, 1, 8'h77);
    check("R9", "idle end silent", {31'h0, done_o}, 32'h0);
    cyc("R9", 1, 0, 0, 0, 8'h00);
    for (int i = 0; i < fr.size() - 1; i++) cyc("R9", 0, 0, 0, 1, fr[i]);
    cyc("R9", 0, 1, 0, 1, fr[fr.size()-1]);
    check("R9", "last byte with end dropped", {31'h0, crc_err_o}, 32'h1);

    // R10: upper halves of seed/residue ignored in 16-bit mode
    mode32_i = 0; preset_i = 32'hABCD_FFFF; resid_i = 32'h1234_F0B8;
    pl = '{8'hC0, 8'hFF, 8'hEE};
    build(0, 32'hFFFF, pl, fr); send("R10", fr, 0);

    // R11: seed zero: own-seed frame passes, default-seed frame fails
    preset_i = 32'h0000_0000; resid_i = 32'h0000_F0B8;
    build(0, 32'h0000, pl, fr); send("R11", fr, 0);
    build(0, 32'hFFFF, pl, fr); send("R11", fr, 1);
    mode32_i = 1; resid_i = 32'hDEBB_20E3;
    build(1, 32'hFFFF_FFFF, pl, fr); send("R11", fr, 1);
    build(1, 32'h0, pl, fr); send("R11", fr, 0);

    cyc("R5", 0, 0, 0, 0, 8'h00);
    check("R5", "pulse is single cycle", {31'h0, done_o}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule